// File: doc/BRIEF.md
# Lenient Predicated Merge

This block joins the two or more arms of a forward branch in a dataflow pipeline. Every arm is computed speculatively, before the condition is known. Each arm then delivers one token per evaluation on its own channel. A token carries the data word together with a predicate bit. In each evaluation exactly one arm carries a true predicate, so the merge never has to arbitrate: the token with the true predicate is the result.

The merge is lenient. It forwards the winning token to its output register as soon as that token arrives. It does not wait for the slower arms, for example a multiply on an arm that was not chosen. The losing tokens are still accepted when they arrive, one per arm, and thrown away. The next evaluation starts only after every arm has delivered its token for the current one, so tokens from different evaluations never mix.

A typical use is a conditional assignment such as "result is the negation of x when x > 0, otherwise b times x". The negation arm and the product arm feed the two inputs, and the comparison feeds their predicates in complementary form. All channels use a valid/ready handshake.

Top module: `lenient_merge`

## Requirements
- R1: After reset, `out_valid` is low and every bit of `in_ready` is high.
- R2: A token whose predicate is 1 is accepted when the output register is empty or is being read in the same cycle. `out_valid` is high on the next cycle, and `out_data` then holds that token's data.
- R3: The output is produced even when no token has yet arrived on any other input of the same evaluation.
- R4: A token whose predicate is 0 is accepted whatever the state of the output register. Its data never reaches `out_data`.
- R5: Once an input has delivered its token for the current evaluation, its `in_ready` stays low until every input has delivered.
- R6: In the cycle after the last input of an evaluation delivers its token, every input is ready again for the next evaluation.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.
- R8: While the output register is full and not being read, a token whose predicate is 1 is not accepted.
- R9: Exactly one output is produced per evaluation, in evaluation order. No output is added or lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | N | Per-input token valid |
| in_pred | input | N | Per-input predicate; 1 marks the selected arm |
| in_data | input | N*W | Per-input data; input i occupies bits [i*W +: W] |
| in_ready | output | N | Per-input ready |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | W | Result data |

## Verification
The hardest situation to reach is when the winning token of the next evaluation is already waiting while a losing token of the current one is still missing, and the output is stalled at the same time. Only the bookkeeping that tracks which inputs have delivered keeps the two evaluations apart in that case. The random phase runs an independent driver per input, each with its own random gaps. It also adds occasional long delays on the losing arm and random back-pressure on the output, so these overlaps happen often. Each time an input hands over a token, the bench checks that every other input has already finished the previous evaluation. A short directed phase first covers the stalled-output cases one at a time.

// File: rtl/lenient_merge.sv
module lenient_merge #(
  parameter int N = 2,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   in_valid,
  input  logic [N-1:0]   in_pred,
  input  logic [N*W-1:0] in_data,
  output logic [N-1:0]   in_ready,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   out_data
);
  logic [N-1:0] done_q;
  logic [N-1:0] take;
  logic [N-1:0] done_nx;
  logic [W-1:0] pick;
  logic         space;
  logic         fire;

  assign space    = !out_valid || out_ready;
  assign in_ready = ~done_q & (~in_pred | {N{space}});
  assign take     = in_valid & in_ready;
  assign fire     = |(take & in_pred);
  assign done_nx  = done_q | take;

  always_comb begin
    pick = '0;
    for (int i = 0; i < N; i++)
      if (take[i] && in_pred[i]) pick = pick | in_data[i*W +: W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      done_q <= (&done_nx) ? '0 : done_nx;
      if (fire) begin
        out_valid <= 1'b1;
        out_data  <= pick;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

module lenient_merge_chk #(
  parameter int N = 2,
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   in_valid,
  input logic [N-1:0]   in_pred,
  input logic [N*W-1:0] in_data,
  input logic [N-1:0]   in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [W-1:0]   out_data
);
  logic [N-1:0] sel_hs;
  logic         sel_take;
  logic [W-1:0] sel_data;
  logic [1:0]   pend;

  assign sel_hs   = in_valid & in_ready & in_pred;
  assign sel_take = |sel_hs;

  always_comb begin
    sel_data = '0;
    for (int i = 0; i < N; i++)
      if (sel_hs[i]) sel_data = in_data[i*W +: W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else pend <= pend + {1'b0, sel_take} - {1'b0, out_valid && out_ready};
  end

  AST_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid); // R1
  AST_FIRE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    sel_take |=> out_valid && out_data == $past(sel_data)); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R7
  AST_NO_TAKE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !sel_take); // R8
  AST_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_hs) <= 1); // R9
  AST_TOKEN_BAL: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= 2'd1); // R9
endmodule

bind lenient_merge lenient_merge_chk #(.N(N), .W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pred(in_pred),
  .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/lenient_merge_tb_top.sv
module lenient_merge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int E = 400;
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] in_valid = '0;
  logic [1:0] in_pred = '0;
  logic [2*W-1:0] in_data = '0;
  logic [1:0] in_ready;
  logic out_valid;
  logic [W-1:0] out_data;
  logic out_ready;
  logic dir_rdy = 1'b0;
  logic sink_rdy = 1'b0;
  logic rnd_mode = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int out_cnt = 0;
  int acc [2];
  logic [W-1:0] xs [E];
  logic [W-1:0] bs [E];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign out_ready = rnd_mode ? sink_rdy : dir_rdy;

  lenient_merge #(.N(2), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pred(in_pred),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic bit pos(input logic [W-1:0] x);
    return $signed(x) > 0;
  endfunction

  function automatic logic [W-1:0] arm_val(input int i, input int e);
    logic [W-1:0] r;
    if (i == 0) r = -xs[e];
    else r = bs[e] * xs[e];
    return r;
  endfunction

  function automatic logic [W-1:0] expv(input int e);
    return pos(xs[e]) ? arm_val(0, e) : arm_val(1, e);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input int i);
    for (int e = 0; e < E; e++) begin
      int gap;
      bit p;
      p = (i == 0) ? pos(xs[e]) : !pos(xs[e]);
      gap = $urandom % 4;
      if (!p && ($urandom % 5) == 0) gap += 12;
      repeat (gap) @(negedge clk);
      @(negedge clk);
      in_valid[i] = 1'b1;
      in_pred[i] = p;
      in_data[i*W +: W] = arm_val(i, e);
      #1;
      while (!in_ready[i]) begin
        @(negedge clk);
        #1;
      end
      for (int j = 0; j < 2; j++)
        if (j != i) chk(acc[j] >= e, "R5 other input finished previous evaluation", acc[j], e);
      @(posedge clk);
      #1;
      in_valid[i] = 1'b0;
      in_pred[i] = 1'b0;
      acc[i]++;
    end
  endtask

  initial begin
    logic [W-1:0] hold_d;
    bit stall;
    stall = 1'b0;
    hold_d = '0;
    wait (rnd_mode);
    forever begin
      @(negedge clk);
      sink_rdy = ($urandom % 10) < 6;
      #2;
      if (stall) chk(out_valid && out_data == hold_d, "R7 stalled output held", out_data, hold_d);
      if (out_valid && sink_rdy) begin
        chk(out_cnt < E && out_data == expv(out_cnt), "R9 R2 result in order", out_data,
            out_cnt < E ? expv(out_cnt) : '0);
        out_cnt++;
      end
      stall = out_valid && !sink_rdy;
      hold_d = out_data;
    end
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired, outputs=%0d expected=%0d", out_cnt, E);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1));
    acc[0] = 0;
    acc[1] = 0;
    for (int e = 0; e < E; e++) begin
      xs[e] = W'($urandom);
      bs[e] = W'($urandom % 64);
    end
    xs[0] = 16'h0000;
    xs[1] = 16'h7FFF;
    xs[2] = 16'h8000;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!out_valid, "R1 out_valid low after reset", out_valid, 0);
    chk(in_ready == 2'b11, "R1 all inputs ready after reset", in_ready, 2'b11);

    in_valid[0] = 1'b1; in_pred[0] = 1'b1; in_data[0 +: W] = 16'hFFFB;
    #1;
    chk(in_ready[0], "R2 selected accepted with empty output", in_ready[0], 1);
    @(posedge clk); #1;
    in_valid[0] = 1'b0; in_pred[0] = 1'b0;
    @(negedge clk); #1;
    chk(out_valid && out_data == 16'hFFFB, "R3 R2 output without other arm", out_data, 16'hFFFB);
    chk(!in_ready[0], "R5 delivered input not ready", in_ready[0], 0);

    repeat (3) begin
      @(negedge clk); #1;
      chk(out_valid && out_data == 16'hFFFB, "R7 held under back-pressure", out_data, 16'hFFFB);
    end
    in_valid[0] = 1'b1; in_data[0 +: W] = 16'h1234;
    #1;
    chk(!in_ready[0], "R5 second token refused", in_ready[0], 0);
    in_valid[0] = 1'b0;

    in_valid[1] = 1'b1; in_pred[1] = 1'b0; in_data[W +: W] = 16'h000F;
    #1;
    chk(in_ready[1], "R4 unselected accepted while output full", in_ready[1], 1);
    @(posedge clk); #1;
    in_valid[1] = 1'b0;
    @(negedge clk); #1;
    chk(in_ready == 2'b11, "R6 new evaluation ready", in_ready, 2'b11);
    chk(out_valid && out_data == 16'hFFFB, "R4 dropped data not shown", out_data, 16'hFFFB);

    in_valid[1] = 1'b1; in_pred[1] = 1'b1; in_data[W +: W] = 16'h0042;
    #1;
    chk(!in_ready[1], "R8 selected refused while full", in_ready[1], 0);
    @(negedge clk); #1;
    chk(!in_ready[1], "R8 still refused", in_ready[1], 0);
    dir_rdy = 1'b1;
    #1;
    chk(in_ready[1], "R8 accepted while output drains", in_ready[1], 1);
    @(posedge clk); #1;
    in_valid[1] = 1'b0; in_pred[1] = 1'b0; dir_rdy = 1'b0;
    @(negedge clk); #1;
    chk(out_valid && out_data == 16'h0042, "R2 drain-and-fire result", out_data, 16'h0042);

    in_valid[0] = 1'b1; in_pred[0] = 1'b0; in_data[0 +: W] = 16'h0007;
    @(posedge clk); #1;
    in_valid[0] = 1'b0;
    dir_rdy = 1'b1;
    @(posedge clk); #1;
    chk(!out_valid, "R9 single output per evaluation", out_valid, 0);
    chk(in_ready == 2'b11, "R6 ready after completed evaluation", in_ready, 2'b11);
    dir_rdy = 1'b0;

    rnd_mode = 1'b1;
    fork
      drive(0);
      drive(1);
    join
    wait (out_cnt == E);
    repeat (3) @(negedge clk);
    #3;
    chk(out_cnt == E, "R9 output count", out_cnt, E);
    chk(!out_valid, "R9 no extra output", out_valid, 0);
    chk(in_ready == 2'b11, "R6 no leaked token at end", in_ready, 2'b11);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule